// File: doc/BRIEF.md
# Page-program packet receiver

This block sits behind an I2C target and turns its received byte stream into flash page writes. While the in-system-programming enable bit is set, each write transaction is parsed as a header byte, a 32-bit destination address and one page of data. The data bytes are forwarded one by one to a downstream page-write port. A strobe then marks the end of the complete page, with the destination address held beside it.

A CRC-32 is computed over every page and compared against a host-written expected value. The host tracks progress by polling a status word. That word carries a page-done count, which the host compares with its own loop count, and two sticky CRC error flags. A write-1-to-clear register resets the flags. A 26-bit configuration register holds the flash access settings. One of its fields is decoded into a dummy-cycle count for the flash sequencer.

Top module: `page_prog_rx`

## Requirements
- R1: After reset the status word, the mode register and the configuration register read zero, and `pg_valid` and `page_ready` are low.
- R2: Received bytes are parsed only while bit 0 of the mode register (select 0, bits 2:0 stored) is 1. While it is 0, no byte reaches the page port and the status word does not change.
- R3: A packet is accepted only when its first byte is 0xFA. The next four bytes form the address, most significant byte first, and that address is on `pg_addr` when `page_ready` pulses.
- R4: Each of the 256 data bytes appears on `pg_byte` with `pg_valid` high, one cycle after it is received and in arrival order.
- R5: `page_ready` pulses for one cycle, together with the 256th data byte on the page port. In that same cycle the page-done count (status bits 19:0) goes up by one, but only if configuration bit 3 is set. The count does not change when that bit is clear.
- R6: A packet whose first byte is not 0xFA, or that ends (`rx_end`) before 256 data bytes, produces no `page_ready` and leaves the count unchanged.
- R7: When configuration bit 1 is set, the page CRC is compared with the expected-CRC register (select 2). The CRC is reflected CRC-32 with polynomial 0xEDB88320, initial value and final XOR all ones. On a mismatch, status bit 28 is set if it was clear, otherwise bit 29 is set. A match, or CRC checking disabled, leaves both flags unchanged.
- R8: The status word (select 3) carries the count in bits 19:0, flag 0 in bit 28 and flag 1 in bit 29. All other bits read zero.
- R9: A write to the clear register (select 4) with bit 28 set clears flag 0, and with bit 29 set clears flag 1. Each flag is cleared independently.
- R10: The configuration register (select 1) keeps only the bits in mask 0x02FFFF3E and reads zero elsewhere. The mode register reads back its bits 2:0 only.
- R11: `dummy_cycles` decodes configuration bits 23:21 as 0→8, 1→6, 2→8, 3→10, and any other code →8.
- R12: Data bytes beyond the 256th are ignored until `rx_end`. The next packet after `rx_end` is parsed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte from the I2C target |
| rx_end | input | 1 | End of the current write transaction (stop condition) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mode, 1 config, 2 expected CRC, 3 status, 4 clear |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| pg_valid | output | 1 | Page data byte valid |
| pg_byte | output | 8 | Page data byte |
| pg_addr | output | 32 | Destination address of the current page |
| page_ready | output | 1 | One-cycle strobe: a complete page has been delivered |
| isp_cfg | output | 32 | Configuration register contents |
| dummy_cycles | output | 4 | Decoded flash dummy-cycle count |

## Verification
On every cycle, the assertions check the following:
- `page_ready` never fires without the enable bit set in the previous cycle, and always coincides with a data byte.
- Every page-port byte traces back to a received byte.
- The count only ever steps up by one.
- Flag 1 is raised only while flag 0 is already set.

The bench scenarios cover the rest:
- The CRC value itself and the flag sequence over several pages.
- The dropping of short and wrongly headed packets.
- Address byte order and the streamed byte contents.
- The effect of the count-enable bit and the register masks, clears and decode.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_CRCX = 3'd2,
    SEL_DONE = 3'd3,
    SEL_CLR  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } pstate_e;

  localparam logic [31:0] CFG_MASK  = 32'h02FF_FF3E;
  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
  localparam int          FLAG0_BIT = 28;
  localparam int          FLAG1_BIT = 29;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pprx_parser.sv
module pprx_parser
  import pprx_pkg::*;
#(
  parameter int          DATA_BYTES = 256,
  parameter int          ADDR_BYTES = 4,
  parameter logic [7:0]  HEADER     = 8'hFA,
  localparam int         AW         = 8 * ADDR_BYTES,
  localparam int         IMAX       = (DATA_BYTES > ADDR_BYTES) ? DATA_BYTES : ADDR_BYTES,
  localparam int         IW         = (IMAX > 1) ? $clog2(IMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isp_en,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_end,
  output logic          hdr_ok,
  output logic          data_fire,
  output logic          data_last,
  output logic          pg_valid,
  output logic [7:0]    pg_byte,
  output logic [AW-1:0] pg_addr,
  output logic          page_ready
);

  pstate_e       st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    st_n      = st_q;
    idx_n     = idx_q;
    addr_n    = addr_q;
    hdr_ok    = 1'b0;
    data_fire = 1'b0;
    data_last = 1'b0;
    if (!isp_en || rx_end) begin
      st_n  = ST_HDR;
      idx_n = '0;
    end else if (rx_valid) begin
      case (st_q)
        ST_HDR: begin
          idx_n = '0;
          if (rx_byte == HEADER) begin
            hdr_ok = 1'b1;
            st_n   = ST_ADDR;
          end else begin
            st_n = ST_SKIP;
          end
        end
        ST_ADDR: begin
          if (AW > 8) addr_n = {addr_q[AW-9:0], rx_byte};
          else        addr_n = AW'(rx_byte);
          if (idx_q == IW'(ADDR_BYTES - 1)) begin
            st_n  = ST_DATA;
            idx_n = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_fire = 1'b1;
          if (idx_q == IW'(DATA_BYTES - 1)) begin
            data_last = 1'b1;
            st_n      = ST_SKIP;
            idx_n     = '0;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HDR;
      idx_q      <= '0;
      addr_q     <= '0;
      pg_valid   <= 1'b0;
      pg_byte    <= '0;
      page_ready <= 1'b0;
    end else begin
      st_q       <= st_n;
      idx_q      <= idx_n;
      addr_q     <= addr_n;
      pg_valid   <= data_fire;
      page_ready <= data_last;
      if (data_fire) pg_byte <= rx_byte;
    end
  end

  assign pg_addr = addr_q;

  a_r2_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    page_ready |-> $past(isp_en));

  a_r4_stream_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    pg_valid |-> $past(rx_valid));

  a_r5_ready_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    page_ready |-> pg_valid);

endmodule

// File: rtl/pprx_crc.sv
module pprx_crc
  import pprx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        fire,
  input  logic        last,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_out
);

  logic [31:0] crc_q, crc_n, step;

  assign step    = crc32_step(crc_q, byte_in);
  assign crc_out = ~step;

  always_comb begin
    crc_n = crc_q;
    if (restart || (fire && last)) crc_n = CRC_SEED;
    else if (fire)                 crc_n = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/pprx_regs.sv
module pprx_regs
  import pprx_pkg::*;
#(
  parameter int COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               page_done,
  input  logic [31:0]        crc_value,
  output logic               isp_en,
  output logic [31:0]        cfg,
  output logic [3:0]         dummy_cycles
);

  reg_sel_e           sel;
  logic [2:0]         mode_q, mode_n;
  logic [31:0]        cfg_q, cfg_n;
  logic [31:0]        crcx_q, crcx_n;
  logic [COUNT_W-1:0] cnt_q, cnt_n;
  logic               f0_q, f0_n, f1_q, f1_n;
  logic [31:0]        status;

  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    mode_n = mode_q;
    cfg_n  = cfg_q;
    crcx_n = crcx_q;
    cnt_n  = cnt_q;
    f0_n   = f0_q;
    f1_n   = f1_q;
    if (reg_we) begin
      case (sel)
        SEL_MODE: mode_n = reg_wdata[2:0];
        SEL_CFG:  cfg_n  = reg_wdata & CFG_MASK;
        SEL_CRCX: crcx_n = reg_wdata;
        SEL_CLR: begin
          if (reg_wdata[FLAG0_BIT]) f0_n = 1'b0;
          if (reg_wdata[FLAG1_BIT]) f1_n = 1'b0;
        end
        default: ;
      endcase
    end
    if (page_done) begin
      if (cfg_q[3]) cnt_n = cnt_q + 1'b1;
      if (cfg_q[1] && (crc_value != crcx_q)) begin
        if (f0_q) f1_n = 1'b1;
        else      f0_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cfg_q  <= '0;
      crcx_q <= '0;
      cnt_q  <= '0;
      f0_q   <= 1'b0;
      f1_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cfg_q  <= cfg_n;
      crcx_q <= crcx_n;
      cnt_q  <= cnt_n;
      f0_q   <= f0_n;
      f1_q   <= f1_n;
    end
  end

  always_comb begin
    status            = 32'(cnt_q);
    status[FLAG0_BIT] = f0_q;
    status[FLAG1_BIT] = f1_q;
  end

  always_comb begin
    case (sel)
      SEL_MODE: reg_rdata = {29'd0, mode_q};
      SEL_CFG:  reg_rdata = cfg_q;
      SEL_CRCX: reg_rdata = crcx_q;
      SEL_DONE: reg_rdata = status;
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    case (cfg_q[23:21])
      3'd1:    dummy_cycles = 4'd6;
      3'd3:    dummy_cycles = 4'd10;
      default: dummy_cycles = 4'd8;
    endcase
  end

  assign isp_en = mode_q[0];
  assign cfg    = cfg_q;

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + COUNT_W'(1)));

  a_r7_flag1_after_flag0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f1_q) |-> $past(f0_q));

endmodule

// File: rtl/page_prog_rx.sv
module page_prog_rx
  import pprx_pkg::*;
#(
  parameter int         DATA_BYTES = 256,
  parameter int         ADDR_BYTES = 4,
  parameter int         COUNT_W    = 20,
  parameter logic [7:0] HEADER     = 8'hFA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    rx_end,
  input  logic                    reg_we,
  input  logic [2:0]              reg_sel,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    pg_valid,
  output logic [7:0]              pg_byte,
  output logic [8*ADDR_BYTES-1:0] pg_addr,
  output logic                    page_ready,
  output logic [31:0]             isp_cfg,
  output logic [3:0]              dummy_cycles
);

  logic [1:0]  rst_sync;
  logic        rst_ni;
  logic        isp_en, hdr_ok, data_fire, data_last;
  logic [31:0] crc_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  pprx_parser #(
    .DATA_BYTES (DATA_BYTES),
    .ADDR_BYTES (ADDR_BYTES),
    .HEADER     (HEADER)
  ) u_parser (
    .clk        (clk),
    .rst_n      (rst_ni),
    .isp_en     (isp_en),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_end     (rx_end),
    .hdr_ok     (hdr_ok),
    .data_fire  (data_fire),
    .data_last  (data_last),
    .pg_valid   (pg_valid),
    .pg_byte    (pg_byte),
    .pg_addr    (pg_addr),
    .page_ready (page_ready)
  );

  pprx_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_ni),
    .restart (hdr_ok),
    .fire    (data_fire),
    .last    (data_last),
    .byte_in (rx_byte),
    .crc_out (crc_value)
  );

  pprx_regs #(
    .COUNT_W (COUNT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_ni),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .page_done    (data_last),
    .crc_value    (crc_value),
    .isp_en       (isp_en),
    .cfg          (isp_cfg),
    .dummy_cycles (dummy_cycles)
  );

endmodule

// File: tb/page_prog_rx_tb.sv
module page_prog_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_end, reg_we;
  logic [7:0]  rx_byte;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata, pg_addr, isp_cfg;
  logic        pg_valid, page_ready;
  logic [7:0]  pg_byte;
  logic [3:0]  dummy_cycles;

  always #2.5 clk = ~clk;

  page_prog_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pg_valid(pg_valid), .pg_byte(pg_byte), .pg_addr(pg_addr), .page_ready(page_ready),
    .isp_cfg(isp_cfg), .dummy_cycles(dummy_cycles)
  );

  int nchk = 0, nerr = 0;
  logic [7:0]  pkt [0:259];
  int          out_idx, bad_bytes, rdy_cnt;
  logic [31:0] rdy_addr, rd;

  // fields: en, header, count-enable, crc-enable, crc-good, data length, seed
  localparam int NV = 9;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {1'b1, 8'hFA, 1'b1, 1'b1, 1'b1, 9'd256, 8'h11, 3'b0},
    {1'b1, 8'hFA, 1'b1, 1'b1, 1'b0, 9'd256, 8'h22, 3'b0},
    {1'b1, 8'hFA, 1'b1, 1'b0, 1'b0, 9'd256, 8'h33, 3'b0},
    {1'b0, 8'hFA, 1'b1, 1'b1, 1'b1, 9'd256, 8'h44, 3'b0},
    {1'b1, 8'h5A, 1'b1, 1'b1, 1'b1, 9'd256, 8'h55, 3'b0},
    {1'b1, 8'hFA, 1'b1, 1'b1, 1'b1, 9'd100, 8'h66, 3'b0},
    {1'b1, 8'hFA, 1'b1, 1'b1, 1'b0, 9'd256, 8'h77, 3'b0},
    {1'b1, 8'hFA, 1'b0, 1'b1, 1'b1, 9'd256, 8'h88, 3'b0},
    {1'b1, 8'hFA, 1'b1, 1'b1, 1'b1, 9'd256, 8'h99, 3'b0}
  };

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pkt[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (pg_valid) begin
      if (out_idx >= 260 || pg_byte !== pkt[out_idx]) bad_bytes++;
      out_idx++;
    end
    if (page_ready) begin
      rdy_cnt++;
      rdy_addr = pg_addr;
    end
  endtask

  task automatic send_packet(input logic [7:0] hdr, input logic [31:0] a, input int n);
    out_idx = 0; bad_bytes = 0; rdy_cnt = 0; rdy_addr = 'x;
    send_byte(hdr);
    for (int k = 3; k >= 0; k--) send_byte(a[8*k +: 8]);
    for (int i = 0; i < n; i++) send_byte(pkt[i]);
    @(negedge clk); rx_end = 1'b1;
    @(negedge clk); rx_end = 1'b0;
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 260; i++) pkt[i] = 8'(i * 7 + 3 * i / 5) ^ seed;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] m_cnt;
    logic        m_f0, m_f1;
    rst_n = 1'b0; rx_valid = 0; rx_end = 0; rx_byte = 0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pg_valid", {31'd0, pg_valid}, 32'd0);
    check("R1 page_ready", {31'd0, page_ready}, 32'd0);
    rdreg(3'd3, rd); check("R1 status", rd, 32'd0);
    rdreg(3'd0, rd); check("R1 mode", rd, 32'd0);
    rdreg(3'd1, rd); check("R1 cfg", rd, 32'd0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    m_cnt = 0; m_f0 = 0; m_f1 = 0;
    for (int v = 0; v < NV; v++) begin
      logic        en, cen, ken, good, ok;
      logic [7:0]  hdr, seed;
      int          n, exp_stream;
      logic [31:0] a, crc;
      en = VEC[v][31]; hdr = VEC[v][30:23]; cen = VEC[v][22]; ken = VEC[v][21];
      good = VEC[v][20]; n = int'(VEC[v][19:11]); seed = VEC[v][10:3];
      a = 32'h3800_0000 + 32'(v) * 32'd256;
      fill(seed);
      crc = ref_crc(256);
      wr(3'd1, {28'd0, cen, 1'b0, ken, 1'b0});
      wr(3'd2, good ? crc : ~crc);
      wr(3'd0, {31'd0, en});
      send_packet(hdr, a, n);
      ok = en && (hdr == 8'hFA) && (n == 256);
      exp_stream = (en && hdr == 8'hFA) ? n : 0;
      if (ok && cen) m_cnt++;
      if (ok && ken && !good) begin
        if (m_f0) m_f1 = 1'b1; else m_f0 = 1'b1;
      end
      check("R4 stream length", 32'(out_idx), 32'(exp_stream));
      check("R4 stream bytes", 32'(bad_bytes), 32'd0);
      check("R5 R6 page_ready count", 32'(rdy_cnt), ok ? 32'd1 : 32'd0);
      if (ok) check("R3 page address", rdy_addr, a);
      rdreg(3'd3, rd);
      check("R5 R7 R8 status", rd, {2'b00, m_f1, m_f0, 8'd0, m_cnt[19:0]});
    end

    // R12: overlong packet, then a normal one
    wr(3'd1, 32'h8);
    wr(3'd0, 32'd1);
    fill(8'hC3);
    send_packet(8'hFA, 32'h3800_1000, 260);
    check("R12 overlong stream length", 32'(out_idx), 32'd256);
    check("R12 overlong ready", 32'(rdy_cnt), 32'd1);
    fill(8'h3C);
    send_packet(8'hFA, 32'h3800_1100, 256);
    check("R12 next packet ready", 32'(rdy_cnt), 32'd1);
    check("R12 next packet address", rdy_addr, 32'h3800_1100);
    rdreg(3'd3, rd);
    check("R12 count", rd & 32'h000F_FFFF, m_cnt + 2);

    // R9 independent clears, R8 layout
    check("R8 unused bits zero", rd & ~32'h300F_FFFF, 32'd0);
    wr(3'd4, 32'h1000_0000);
    rdreg(3'd3, rd);
    check("R9 flag0 cleared only", rd & 32'h3000_0000, 32'h2000_0000);
    wr(3'd4, 32'h2000_0000);
    rdreg(3'd3, rd);
    check("R9 flag1 cleared", rd & 32'h3000_0000, 32'h0000_0000);

    // R10 masks
    wr(3'd1, 32'hFFFF_FFFF);
    rdreg(3'd1, rd); check("R10 cfg mask", rd, 32'h02FF_FF3E);
    check("R10 cfg port", isp_cfg, 32'h02FF_FF3E);
    wr(3'd0, 32'hFFFF_FFFF);
    rdreg(3'd0, rd); check("R10 mode mask", rd, 32'h7);

    // R11 dummy-cycle decode
    wr(3'd1, 32'd0 << 21); check("R11 code0", 32'(dummy_cycles), 32'd8);
    wr(3'd1, 32'd1 << 21); check("R11 code1", 32'(dummy_cycles), 32'd6);
    wr(3'd1, 32'd2 << 21); check("R11 code2", 32'(dummy_cycles), 32'd8);
    wr(3'd1, 32'd3 << 21); check("R11 code3", 32'(dummy_cycles), 32'd10);
    wr(3'd1, 32'd5 << 21); check("R11 code5", 32'(dummy_cycles), 32'd8);

    finish_run();
  end

endmodule